// File: doc/BRIEF.md
# Condition Bit Logic Unit

This block holds a 32-bit condition register and performs one single-bit Boolean operation per clock. An operation names two source bits and one target bit by 5-bit indices, together with a 10-bit function code. The two source bits are combined and the result replaces the target bit, while every other bit keeps its value. The full register value is always visible on an output, so a neighbouring branch unit can decode its fields directly.

Indices count from the most significant bit. Index 0 is the leftmost bit of the register (`cr_value[31]`) and index 31 is the rightmost (`cr_value[0]`).

Common bit moves need no extra hardware, only repeated operands:
- XOR of a bit with itself clears it.
- Equivalence of a bit with itself sets it.
- OR with both sources equal copies a bit.
- NOR with both sources equal inverts a bit.

A function code outside the supported set changes nothing in the register and raises a one-cycle illegal flag.

Top module: `crbit_logic_unit`

## Requirements
- R1: While `rst_n` is low, and after its release, `cr_value` is all zeros and `op_illegal` is low.
- R2: Index i addresses `cr_value[31-i]`. Setting index 0 on a cleared register gives `32'h8000_0000`, and setting index 31 gives `32'h0000_0001`. The new value is visible after the clock edge at which `op_valid` was high.
- R3: A valid operation changes no register bit other than the one addressed by `op_bt`.
- R4: Code 257 writes A AND B, code 449 writes A OR B, and code 193 writes A XOR B. Here A is the bit at `op_ba` and B is the bit at `op_bb`.
- R5: Code 225 writes NOT(A AND B), code 33 writes NOT(A OR B), and code 289 writes NOT(A XOR B).
- R6: Code 129 writes A AND NOT B.
- R7: Source bits are taken from the register value before the update, so `op_bt` may equal `op_ba` or `op_bb`.
- R8: The repeated-operand forms behave as follows:
  - XOR of a bit with itself writes 0.
  - Equivalence of a bit with itself writes 1.
  - OR with equal sources copies the source bit.
  - NOR with equal sources writes the inverse of the source bit.
- R9: A valid operation with any other code leaves the register unchanged. It drives `op_illegal` high during the following cycle only.
- R10: With `op_valid` low, the register holds and `op_illegal` is low in the following cycle, whatever the code and index inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe; the update takes place on this edge |
| op_code | input | 10 | Function code |
| op_bt | input | 5 | Target bit index, MSB-first |
| op_ba | input | 5 | First source bit index, MSB-first |
| op_bb | input | 5 | Second source bit index, MSB-first |
| cr_value | output | 32 | Current condition register contents |
| op_illegal | output | 1 | High for one cycle after an unsupported code |

## Verification
The hardest case to reach is an operation whose target is also one of its sources, since the result then depends on the bit value from before that same edge. The bench first sets or clears the shared bit with the self-referencing alias forms. It then issues in-place operations such as inverting a bit onto itself and AND-with-complement where the target equals the first source. Finally it compares the whole register against a model that reads its sources before writing. Every seven-code truth table is driven with all four source combinations, and each is built up through earlier operations over the ports.

// File: rtl/crl_pkg.sv
package crl_pkg;
    localparam int CODE_W = 10;

    localparam logic [CODE_W-1:0] CODE_AND  = 10'd257;
    localparam logic [CODE_W-1:0] CODE_OR   = 10'd449;
    localparam logic [CODE_W-1:0] CODE_XOR  = 10'd193;
    localparam logic [CODE_W-1:0] CODE_NAND = 10'd225;
    localparam logic [CODE_W-1:0] CODE_NOR  = 10'd33;
    localparam logic [CODE_W-1:0] CODE_EQV  = 10'd289;
    localparam logic [CODE_W-1:0] CODE_ANDC = 10'd129;

    typedef enum logic [2:0] {
        FN_NONE,
        FN_AND,
        FN_OR,
        FN_XOR,
        FN_NAND,
        FN_NOR,
        FN_EQV,
        FN_ANDC
    } crl_fn_e;
endpackage

// File: rtl/crl_decode.sv
module crl_decode
    import crl_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output crl_fn_e           fn,
    output logic              known
);
    always_comb begin
        known = 1'b1;
        unique case (code)
            CODE_AND:  fn = FN_AND;
            CODE_OR:   fn = FN_OR;
            CODE_XOR:  fn = FN_XOR;
            CODE_NAND: fn = FN_NAND;
            CODE_NOR:  fn = FN_NOR;
            CODE_EQV:  fn = FN_EQV;
            CODE_ANDC: fn = FN_ANDC;
            default: begin
                fn    = FN_NONE;
                known = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/crl_bitfn.sv
module crl_bitfn
    import crl_pkg::*;
(
    input  crl_fn_e fn,
    input  logic    a,
    input  logic    b,
    output logic    y
);
    always_comb begin
        unique case (fn)
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_XOR:  y = a ^ b;
            FN_NAND: y = ~(a & b);
            FN_NOR:  y = ~(a | b);
            FN_EQV:  y = ~(a ^ b);
            FN_ANDC: y = a & ~b;
            default: y = 1'b0;
        endcase
    end
endmodule

// File: rtl/crbit_logic_unit.sv
module crbit_logic_unit
    import crl_pkg::*;
#(
    parameter int CR_W = 32,
    localparam int IDX_W = $clog2(CR_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [CODE_W-1:0] op_code,
    input  logic [IDX_W-1:0]  op_bt,
    input  logic [IDX_W-1:0]  op_ba,
    input  logic [IDX_W-1:0]  op_bb,
    output logic [CR_W-1:0]   cr_value,
    output logic              op_illegal
);
    localparam logic [IDX_W-1:0] TOP_POS = IDX_W'(CR_W - 1);

    logic [CR_W-1:0]  cr_q;
    logic [CR_W-1:0]  cr_d;
    logic             illegal_q;
    crl_fn_e          fn;
    logic             known;
    logic             src_a;
    logic             src_b;
    logic             res;
    logic             wr_en;
    logic [IDX_W-1:0] tgt_pos;

    crl_decode u_dec (
        .code  (op_code),
        .fn    (fn),
        .known (known)
    );

    // MSB-first numbering: index i lives at physical bit CR_W-1-i
    assign src_a   = cr_q[TOP_POS - op_ba];
    assign src_b   = cr_q[TOP_POS - op_bb];
    assign tgt_pos = TOP_POS - op_bt;
    assign wr_en   = op_valid && known;

    crl_bitfn u_fn (
        .fn (fn),
        .a  (src_a),
        .b  (src_b),
        .y  (res)
    );

    for (genvar j = 0; j < CR_W; j++) begin : g_bit
        assign cr_d[j] = (wr_en && (tgt_pos == IDX_W'(j))) ? res : cr_q[j];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_q      <= '0;
            illegal_q <= 1'b0;
        end else begin
            cr_q      <= cr_d;
            illegal_q <= op_valid && !known;
        end
    end

    assign cr_value   = cr_q;
    assign op_illegal = illegal_q;

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (cr_q == $past(cr_q)) && !op_illegal);

    p_bad_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !known) |=> (cr_q == $past(cr_q)) && op_illegal);

    p_flag_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_illegal |-> $past(op_valid));

    p_single_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> $countones(cr_q ^ $past(cr_q)) <= 1);

    p_target_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> ((cr_q ^ $past(cr_q))
                      & ~(CR_W'(1) << (CR_W - 1 - int'($past(op_bt))))) == '0);
endmodule

// File: tb/crbit_logic_unit_test.sv
module crbit_logic_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [9:0]  op_code = '0;
    logic [4:0]  op_bt = '0;
    logic [4:0]  op_ba = '0;
    logic [4:0]  op_bb = '0;
    logic [31:0] cr_value;
    logic        op_illegal;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_cr = '0;
    logic        exp_ill = 1'b0;

    always #4 clk = ~clk;

    crbit_logic_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_bt(op_bt), .op_ba(op_ba), .op_bb(op_bb),
        .cr_value(cr_value), .op_illegal(op_illegal)
    );

    function automatic logic model_known(input logic [9:0] c);
        return (c == 10'd257) || (c == 10'd449) || (c == 10'd193) || (c == 10'd225)
            || (c == 10'd33) || (c == 10'd289) || (c == 10'd129);
    endfunction

    function automatic logic model_fn(input logic [9:0] c, input logic a, input logic b);
        case (c)
            10'd257: return a & b;
            10'd449: return a | b;
            10'd193: return a ^ b;
            10'd225: return !(a & b);
            10'd33:  return !(a | b);
            10'd289: return a == b;
            10'd129: return a & !b;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: cr_value=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: op_illegal=%b expected %b", tag, act, exp);
        end
    endtask

    // one operation; model reads sources before writing (R7)
    task automatic do_op(input logic [9:0] c, input logic [4:0] t, input logic [4:0] a,
                         input logic [4:0] b, input string tag);
        logic va;
        logic vb;
        @(negedge clk);
        op_valid = 1'b1; op_code = c; op_bt = t; op_ba = a; op_bb = b;
        va = exp_cr[31 - a];
        vb = exp_cr[31 - b];
        if (model_known(c)) exp_cr[31 - t] = model_fn(c, va, vb);
        exp_ill = !model_known(c);
        @(negedge clk);
        op_valid = 1'b0;
        check32(tag, cr_value, exp_cr);
        check1(tag, op_illegal, exp_ill);
    endtask

    task automatic put_bit(input logic [4:0] idx, input logic v, input string tag);
        if (v) do_op(10'd289, idx, idx, idx, tag);
        else   do_op(10'd193, idx, idx, idx, tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check32("R1 during reset", cr_value, 32'h0);
        check1("R1 during reset", op_illegal, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check32("R1 after reset", cr_value, 32'h0);
        check1("R1 after reset", op_illegal, 1'b0);
    endtask

    task automatic t_mapping();
        do_op(10'd289, 5'd0, 5'd0, 5'd0, "R2 index0");
        check32("R2 index0 literal", cr_value, 32'h8000_0000);
        do_op(10'd289, 5'd31, 5'd31, 5'd31, "R2 index31");
        check32("R2 index31 literal", cr_value, 32'h8000_0001);
        do_op(10'd193, 5'd0, 5'd0, 5'd0, "R8 clear");
        do_op(10'd193, 5'd31, 5'd31, 5'd31, "R8 clear");
        check32("R2 cleared literal", cr_value, 32'h0);
    endtask

    task automatic t_table(input logic [9:0] c, input string tag);
        for (int k = 0; k < 4; k++) begin
            put_bit(5'd4, k[1], tag);
            put_bit(5'd9, k[0], tag);
            do_op(c, 5'd20, 5'd4, 5'd9, tag);
        end
    endtask

    task automatic t_functions();
        t_table(10'd257, "R4 and");
        t_table(10'd449, "R4 or");
        t_table(10'd193, "R4 xor");
        t_table(10'd225, "R5 nand");
        t_table(10'd33,  "R5 nor");
        t_table(10'd289, "R5 eqv");
        t_table(10'd129, "R6 andc");
    endtask

    task automatic t_aliases();
        put_bit(5'd7, 1'b1, "R8 set");
        do_op(10'd449, 5'd12, 5'd7, 5'd7, "R8 move one");
        do_op(10'd33, 5'd13, 5'd7, 5'd7, "R8 not one");
        put_bit(5'd7, 1'b0, "R8 clear");
        do_op(10'd449, 5'd12, 5'd7, 5'd7, "R8 move zero");
        do_op(10'd33, 5'd13, 5'd7, 5'd7, "R8 not zero");
    endtask

    task automatic t_overlap();
        put_bit(5'd3, 1'b1, "R7 prep");
        do_op(10'd33, 5'd3, 5'd3, 5'd3, "R7 invert in place");
        do_op(10'd33, 5'd3, 5'd3, 5'd3, "R7 invert back");
        put_bit(5'd5, 1'b0, "R7 prep");
        do_op(10'd129, 5'd3, 5'd3, 5'd5, "R7 andc bt=ba");
        do_op(10'd193, 5'd5, 5'd3, 5'd5, "R7 xor bt=bb");
    endtask

    task automatic t_pattern();
        for (int i = 0; i < 32; i += 3) put_bit(i[4:0], 1'b1, "R3 fill");
        do_op(10'd257, 5'd1, 5'd0, 5'd3, "R3 neighbours kept");
        do_op(10'd225, 5'd30, 5'd30, 5'd27, "R3 neighbours kept");
        do_op(10'd129, 5'd15, 5'd16, 5'd17, "R3 neighbours kept");
    endtask

    task automatic t_illegal();
        do_op(10'd0, 5'd0, 5'd1, 5'd2, "R9 code 0");
        do_op(10'd258, 5'd6, 5'd6, 5'd6, "R9 code 258");
        do_op(10'd1023, 5'd31, 5'd0, 5'd0, "R9 code 1023");
        do_op(10'd257, 5'd2, 5'd0, 5'd3, "R9 flag drops");
    endtask

    task automatic t_idle();
        @(negedge clk);
        op_valid = 1'b0; op_code = 10'd289; op_bt = 5'd2; op_ba = 5'd2; op_bb = 5'd2;
        @(negedge clk);
        check32("R10 idle legal code", cr_value, exp_cr);
        check1("R10 idle legal code", op_illegal, 1'b0);
        op_code = 10'd5;
        @(negedge clk);
        check32("R10 idle bad code", cr_value, exp_cr);
        check1("R10 idle bad code", op_illegal, 1'b0);
    endtask

    initial begin
        #(8 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_mapping();
        t_functions();
        t_aliases();
        t_overlap();
        t_pattern();
        t_illegal();
        t_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule